// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits each and returns the full signed product of `2*WIDTH` bits. It takes one clock per multiplier bit. It uses radix-2 Booth recoding. A single shifting accumulator holds the running partial product in its upper half and the not-yet-consumed multiplier bits in its lower half. One guard bit sits below the lowest position. The multiplicand is captured once and does not move. One add/subtract unit acts only on the upper half of the accumulator.

A client pulses `start_i` for one cycle with both operands present. `busy_o` stays high while the iterations run. `done_o` pulses for a single cycle once the last iteration has been written. From then on, `product_o` carries the result until the client issues another accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` seen at a clock edge while `busy_o` is 0 captures both operands. Starting from that edge, `busy_o` reads 1.
- R3: When `done_o` is 1, `product_o` equals the signed product of the captured multiplicand and multiplier, exact over the full `2*WIDTH` bits.
- R4: Each iteration looks at the accumulator's lowest multiplier bit and the guard bit below it. The pair (1,0) subtracts the multiplicand from the upper half. The pair (0,1) adds it. The pairs (0,0) and (1,1) leave the upper half unchanged. The whole accumulator then shifts right by one with sign extension. This yields correct products for multipliers made of long runs of ones, long runs of zeros and alternating bits.
- R5: The add/subtract is formed one bit wider than the operands. As a result, the most negative multiplicand gives a correct product, including (-2^(WIDTH-1)) times itself.
- R6: `done_o` is 1 for exactly one cycle. That cycle follows the `WIDTH` edges after the accepting edge, which is `WIDTH`+1 edges after `start_i` is sampled. `done_o` is never 1 together with `busy_o`.
- R7: `busy_o` stays 1 for exactly `WIDTH` cycles after an accepted start, and `done_o` is 0 during that time.
- R8: A `start_i` seen while `busy_o` is 1 is ignored. The running operation completes with its original operands and on its original schedule.
- R9: After `done_o`, `product_o` keeps its value while no start is accepted.
- R10: Small known cases hold: 2 × 7 = 14 and 2 × (-3) = -6, shown across the full product width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a multiply |
| mcand_i | input | WIDTH | Signed multiplicand, sampled on an accepted start |
| mplier_i | input | WIDTH | Signed multiplier, sampled on an accepted start |
| busy_o | output | 1 | High while iterations are running |
| done_o | output | 1 | One-cycle pulse when the product is final |
| product_o | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The operand table crosses several kinds of operand pairs, and each kind exposes a different fault.
- Positive-by-positive and mixed-sign pairs separate a swapped add/subtract selection from a correct one.
- All-ones and alternating-bit multipliers force many adjacent run boundaries. An error in the pair decode or in the guard-bit handoff shows up there.
- The most negative multiplicand and multiplier, squared and crossed with small values, tell a plain `WIDTH`-bit adder apart from the widened one, because only the widened one shifts in the correct sign.
- Zero operands and ±1 operands catch shift-count and sign-extension mistakes.
- A start pulsed in the middle of an operation, with different operands, shows whether a busy start is truly ignored.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2
  } booth_op_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [1:0] pair_i,   // {current bit, bit to its right}
  output booth_op_t  op_o
);
  always_comb begin
    unique case (pair_i)
      2'b10:   op_o = OP_SUB;  // start of a run of ones
      2'b01:   op_o = OP_ADD;  // end of a run of ones
      default: op_o = OP_NOP;  // inside a run
    endcase
  end
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  booth_op_t          op_i,
  input  logic [WIDTH-1:0]   hi_i,
  input  logic [WIDTH-1:0]   lo_i,
  input  logic [WIDTH-1:0]   mcand_i,
  output logic [2*WIDTH:0]   acc_o
);
  localparam int EW = WIDTH + 1;

  logic [EW-1:0] hi_ext;
  logic [EW-1:0] mc_ext;
  logic [EW-1:0] sum;

  assign hi_ext = {hi_i[WIDTH-1], hi_i};
  assign mc_ext = {mcand_i[WIDTH-1], mcand_i};

  always_comb begin
    unique case (op_i)
      OP_ADD:  sum = hi_ext + mc_ext;
      OP_SUB:  sum = hi_ext - mc_ext;
      default: sum = hi_ext;
    endcase
  end

  // arithmetic right shift of {sum, lo, guard}: the widened sum supplies the sign
  assign acc_o = {sum, lo_i};
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last   = busy_q & (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = last;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (step_o) begin
      cnt_d = cnt_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R6
  done_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [WIDTH-1:0]     mcand_i,
  input  logic [WIDTH-1:0]     mplier_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [2*WIDTH-1:0]   product_o
);
  localparam int AW = 2 * WIDTH + 1;

  logic [AW-1:0]    acc_q, acc_d, acc_step;
  logic [WIDTH-1:0] mcand_q, mcand_d;
  logic             load, step;
  booth_op_t        op;

  booth_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .load_o (load),
    .step_o (step)
  );

  booth_recode recode_i (
    .pair_i(acc_q[1:0]),
    .op_o  (op)
  );

  booth_step #(.WIDTH(WIDTH)) step_i (
    .op_i   (op),
    .hi_i   (acc_q[AW-1:WIDTH+1]),
    .lo_i   (acc_q[WIDTH:1]),
    .mcand_i(mcand_q),
    .acc_o  (acc_step)
  );

  always_comb begin
    acc_d   = acc_q;
    mcand_d = mcand_q;
    if (load) begin
      acc_d   = {{WIDTH{1'b0}}, mplier_i, 1'b0};
      mcand_d = mcand_i;
    end else if (step) begin
      acc_d = acc_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else begin
      acc_q   <= acc_d;
      mcand_q <= mcand_d;
    end
  end

  assign product_o = acc_q[AW-1:1];

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(mcand_q));
  // R9
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));
  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/booth_seq_mult_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mult_tb_top;
  localparam int W  = 8;
  localparam int PW = 2 * W;
  localparam int NV = 14;

  // each entry: {multiplicand, multiplier}; expected product computed below
  localparam logic [2*W-1:0] VEC [NV] = '{
    {8'd2,   8'd7},    // R10
    {8'd2,   8'hFD},   // R10: 2 x -3
    {8'd0,   8'h5A},
    {8'h7F,  8'h7F},
    {8'h80,  8'h80},   // R5
    {8'h80,  8'h7F},   // R5
    {8'h80,  8'h01},   // R5
    {8'h80,  8'hFF},   // R5
    {8'h13,  8'hFF},   // R4 all ones
    {8'hE5,  8'h55},   // R4 alternating
    {8'h3C,  8'hAA},   // R4 alternating
    {8'hFF,  8'hFF},
    {8'h21,  8'h0F},   // R4 run then zeros
    {8'h9B,  8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  mcand, mplier;
  logic          busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  booth_seq_mult #(.WIDTH(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .busy_o   (busy),
    .done_o   (done),
    .product_o(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] sa, sb;
    sa = $signed({{W{a[W-1]}}, a});
    sb = $signed({{W{b[W-1]}}, b});
    return PW'(sa * sb);
  endfunction

  // start on one edge, follow the schedule, check result and hold
  task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke_busy, input string req);
    logic [PW-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R2", {busy, done}, 2'b10);
    for (int k = 1; k <= W; k++) begin
      if (poke_busy && k == 2) begin
        start = 1'b1; mcand = ~a; mplier = b + 8'd3;
      end
      @(negedge clk);
      start = 1'b0;
      if (k < W) begin
        if (k == 1 || k == W - 1)
          check(busy == 1'b1 && done == 1'b0, "R7", {busy, done}, 2'b10);
      end else begin
        check(done == 1'b1 && busy == 1'b0, "R6", {busy, done}, 2'b01);
        check(product == exp, req, product, exp);
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R6", done, 0);
    check(product == exp, "R9", product, exp);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mcand = '0; mplier = '0;
    #12;
    check(busy == 0 && done == 0 && product == 0, "R1", {busy, done, product}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && product == 0, "R1", {busy, done, product}, 0);

    for (int i = 0; i < NV; i++)
      run_one(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0, "R3");

    // R10 at the small end, checked as full-width patterns
    run_one(8'd2, 8'd7, 1'b0, "R10");
    check(product == 16'h000E, "R10", product, 16'h000E);
    run_one(8'd2, 8'hFD, 1'b0, "R10");
    check(product == 16'hFFFA, "R10", product, 16'hFFFA);

    // R8: start while busy with different operands is ignored
    run_one(8'h35, 8'hC7, 1'b1, "R8");

    // R9: long idle, inputs wiggling without start
    mcand = 8'h11; mplier = 8'h22;
    repeat (6) @(negedge clk);
    check(product == ref_mul(8'h35, 8'hC7), "R9", product, ref_mul(8'h35, 8'hC7));

    // R5: most negative squared, back to back
    run_one(8'h80, 8'h80, 1'b0, "R5");
    check(product == 16'h4000, "R5", product, 16'h4000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule